// File: doc/BRIEF.md
# Bit-Serial Dot-Product Engine

This block computes the signed dot product of `TAPS` coefficient words with `TAPS` data words. The coefficients arrive in parallel on one wide bus. The data words arrive one bit position per clock on a narrow bus that carries one bit per tap. In each clock every tap gates its full coefficient word with its current data bit. A pipelined tree of two-input adders reduces all the gated words to one partial sum for that bit position. A shifting accumulator at the end of the tree weights each partial sum by its bit position and adds it into the running total.

A run begins with a one-cycle `start` strobe. The data bits for bit 0 are presented in that same cycle. The remaining bit positions follow in the next `DW-1` cycles, least significant first. The coefficients stay on the bus for the whole run. When the partial sum for the sign bit has passed through the tree and has been folded in, `result_valid` pulses for one cycle. The result then holds until the next run starts.

Top module: `bsdot_engine`

## Requirements
- R1: In a bit position where a tap's data bit is 0, that tap adds nothing. Where the bit is 1, the tap's whole coefficient, sign-extended, enters the sum for that position.
- R2: When valid, `result` equals the sum over all taps of C_i·A_i. Both operands are read as two's complement. The result is an AW-bit signed word, with AW = CW+DW+L and L = ceil(log2 TAPS) (L is 0 for a single tap).
- R3: Data bits are taken least significant first, one position per clock. The bit present in the cycle where `start` is accepted is bit 0, the next cycle carries bit 1, and so on up to bit DW-1. `data_bits` in any other cycle does not change the result.
- R4: If `start` is accepted in cycle c, `result_valid` is high in cycle c+DW+L and in no earlier cycle of that run.
- R5: `result_valid` stays high for exactly one cycle. `result` keeps its value from that cycle until the next accepted start.
- R6: A `start` in any cycle from acceptance up to the cycle before `result_valid` has no effect. A `start` in the cycle where `result_valid` is high is accepted.
- R7: Bit DW-1 of each data word carries weight -2^(DW-1), and bit CW-1 of each coefficient is its sign. Products of the most negative coefficient and the most negative data word come out exact.
- R8: When TAPS > 1, `result` reads zero in the cycle right after a start is accepted.
- R9: A run started in the cycle where the previous run's `result_valid` is high gives its own correct result, with no idle cycle between the runs.
- R10: After synchronous reset, `result` is 0 and `result_valid` is 0. A `start` in the first cycle after reset is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run strobe; in the accepted cycle, `data_bits` holds bit 0 |
| coef_bus | input | TAPS*CW | Coefficient of tap t in bits [t*CW +: CW], two's complement |
| data_bits | input | TAPS | Current data bit of each tap, bit t for tap t |
| result | output | CW+DW+L | Signed sum of products |
| result_valid | output | 1 | One-cycle pulse when `result` is complete |

## Verification
The bench builds the engine with five taps, 6-bit coefficients and 7-bit data. Five taps is not a power of two, so the tree pads to eight leaves and runs three registered levels. This brings zero-filled leaves, a drain phase of several cycles after the last data bit, and the clear-at-start window into reach. The narrow operand widths make the most negative corner values cheap to hit. At these widths a full-sized sum also exercises the top bits of the 16-bit result. Garbage on the data bus between runs, restart pulses during both the feed and drain phases, and chained runs are compared every cycle against a behavioural model.

// File: rtl/bsdot_pkg.sv
package bsdot_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FEED  = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;

  // Number of registered adder levels needed to reduce n words
  function automatic int tree_depth(input int n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction

endpackage

// File: rtl/bsdot_sequencer.sv
module bsdot_sequencer
  import bsdot_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          drain_done,
  output logic          start_acc,
  output logic          feed_valid,
  output logic          feed_last,
  output logic [IW-1:0] feed_idx,
  output logic          busy
);

  localparam logic [IW-1:0] LAST_IDX = IW'(DW - 1);

  seq_state_e    state_q;
  logic [IW-1:0] cnt_q;

  assign busy       = (state_q != SEQ_IDLE);
  assign start_acc  = start && (state_q == SEQ_IDLE);
  assign feed_valid = start_acc || (state_q == SEQ_FEED);
  assign feed_idx   = start_acc ? '0 : cnt_q;
  assign feed_last  = feed_valid && (feed_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_FEED;
            cnt_q   <= IW'(1);
          end
        end
        SEQ_FEED: begin
          cnt_q <= cnt_q + IW'(1);
          if (cnt_q == LAST_IDX) begin
            state_q <= drain_done ? SEQ_IDLE : SEQ_DRAIN;
          end
        end
        SEQ_DRAIN: begin
          if (drain_done) begin
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (feed_valid && !feed_last) |=> (feed_valid && (feed_idx == $past(feed_idx) + IW'(1)))); // R3

endmodule

// File: rtl/bsdot_tap_gate.sv
module bsdot_tap_gate #(
  parameter int TAPS = 4,
  parameter int CW   = 8,
  parameter int TW   = 10,
  parameter int PADN = 4
) (
  input  logic [TAPS*CW-1:0] coef_bus,
  input  logic [TAPS-1:0]    data_bits,
  output logic [PADN*TW-1:0] leaves
);

  for (genvar t = 0; t < PADN; t++) begin : g_leaf
    if (t < TAPS) begin : g_tap
      logic signed [CW-1:0] c_w;
      assign c_w = coef_bus[t*CW +: CW];
      assign leaves[t*TW +: TW] = data_bits[t] ? TW'(c_w) : '0;
    end else begin : g_pad
      assign leaves[t*TW +: TW] = '0;
    end
  end

endmodule

// File: rtl/bsdot_add_tree.sv
module bsdot_add_tree #(
  parameter int TW  = 10,
  parameter int LVL = 2,
  parameter int IW  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [(1<<LVL)*TW-1:0] leaves,
  input  logic                   in_valid,
  input  logic                   in_last,
  input  logic [IW-1:0]          in_idx,
  output logic [TW-1:0]          sum,
  output logic                   out_valid,
  output logic                   out_last,
  output logic [IW-1:0]          out_idx
);

  localparam int PADN = 1 << LVL;

  if (LVL == 0) begin : g_flat
    assign sum       = leaves;
    assign out_valid = in_valid;
    assign out_last  = in_last;
    assign out_idx   = in_idx;
  end else begin : g_tree
    // Heap layout: node i adds operands 2i and 2i+1; operands at PADN.. are leaves
    logic [TW-1:0] node_q  [1:PADN-1];
    logic [TW-1:0] operand [2:2*PADN-1];
    logic [LVL-1:0] v_q;
    logic [LVL-1:0] l_q;
    logic [IW-1:0]  i_q [LVL];

    always_comb begin
      for (int j = 2; j < PADN; j++) operand[j] = node_q[j];
      for (int j = 0; j < PADN; j++) operand[PADN + j] = leaves[j*TW +: TW];
    end

    always_ff @(posedge clk) begin
      for (int i = 1; i < PADN; i++) begin
        node_q[i] <= operand[2*i] + operand[2*i+1];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= '0;
        l_q <= '0;
        for (int s = 0; s < LVL; s++) i_q[s] <= '0;
      end else begin
        v_q[0] <= in_valid;
        l_q[0] <= in_last;
        i_q[0] <= in_idx;
        for (int s = 1; s < LVL; s++) begin
          v_q[s] <= v_q[s-1];
          l_q[s] <= l_q[s-1];
          i_q[s] <= i_q[s-1];
        end
      end
    end

    assign sum       = node_q[1];
    assign out_valid = v_q[LVL-1];
    assign out_last  = l_q[LVL-1];
    assign out_idx   = i_q[LVL-1];
  end

endmodule

// File: rtl/bsdot_shift_accum.sv
module bsdot_shift_accum #(
  parameter int TW = 10,
  parameter int AW = 18,
  parameter int IW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tv,
  input  logic          tlast,
  input  logic [IW-1:0] tidx,
  input  logic [TW-1:0] tsum,
  output logic [AW-1:0] result,
  output logic          result_valid
);

  logic signed [TW-1:0] tsum_s;
  logic signed [AW-1:0] ext, weighted, base, acc_n;
  logic [AW-1:0]        acc_q;
  logic                 vld_q;

  always_comb begin
    tsum_s   = tsum;
    ext      = AW'(tsum_s);
    weighted = ext << tidx;
    base     = clear ? '0 : acc_q;
    if (!tv)        acc_n = base;
    else if (tlast) acc_n = base - weighted;
    else            acc_n = base + weighted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_n;
      vld_q <= tv && tlast;
    end
  end

  assign result       = acc_q;
  assign result_valid = vld_q;

  AST_SIGN_LAST: assert property (@(posedge clk) disable iff (rst)
    (tv && tlast) |-> (tidx == IW'(DW - 1))); // R7

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid); // R5

endmodule

// File: rtl/bsdot_engine.sv
module bsdot_engine
  import bsdot_pkg::*;
#(
  parameter int TAPS = 4,
  parameter int CW   = 8,
  parameter int DW   = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  start,
  input  logic [TAPS*CW-1:0]                    coef_bus,
  input  logic [TAPS-1:0]                       data_bits,
  output logic [CW+DW+tree_depth(TAPS)-1:0]     result,
  output logic                                  result_valid
);

  localparam int LVL  = tree_depth(TAPS);
  localparam int PADN = 1 << LVL;
  localparam int TW   = CW + LVL;
  localparam int AW   = CW + DW + LVL;
  localparam int IW   = $clog2(DW);
  localparam int AGW  = $clog2(DW + LVL + 1);

  logic          start_acc, feed_valid, feed_last, busy;
  logic [IW-1:0] feed_idx;
  logic [PADN*TW-1:0] leaves;
  logic [TW-1:0] tree_sum;
  logic          tree_valid, tree_last;
  logic [IW-1:0] tree_idx;
  logic          drain_done;

  assign drain_done = tree_valid && tree_last;

  bsdot_sequencer #(.DW(DW), .IW(IW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .drain_done (drain_done),
    .start_acc  (start_acc),
    .feed_valid (feed_valid),
    .feed_last  (feed_last),
    .feed_idx   (feed_idx),
    .busy       (busy)
  );

  bsdot_tap_gate #(.TAPS(TAPS), .CW(CW), .TW(TW), .PADN(PADN)) u_gate (
    .coef_bus  (coef_bus),
    .data_bits (data_bits),
    .leaves    (leaves)
  );

  bsdot_add_tree #(.TW(TW), .LVL(LVL), .IW(IW)) u_tree (
    .clk       (clk),
    .rst       (rst),
    .leaves    (leaves),
    .in_valid  (feed_valid),
    .in_last   (feed_last),
    .in_idx    (feed_idx),
    .sum       (tree_sum),
    .out_valid (tree_valid),
    .out_last  (tree_last),
    .out_idx   (tree_idx)
  );

  bsdot_shift_accum #(.TW(TW), .AW(AW), .IW(IW), .DW(DW)) u_acc (
    .clk          (clk),
    .rst          (rst),
    .clear        (start_acc),
    .tv           (tree_valid),
    .tlast        (tree_last),
    .tidx         (tree_idx),
    .tsum         (tree_sum),
    .result       (result),
    .result_valid (result_valid)
  );

  // Cycles since the last accepted start, saturating; observes run latency
  logic [AGW-1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)                              age_q <= '0;
    else if (start_acc)                   age_q <= '0;
    else if (age_q != AGW'(DW + LVL))     age_q <= age_q + AGW'(1);
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (age_q == AGW'(DW - 1 + LVL))); // R4

  AST_IDLE_AT_VALID: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !busy); // R6

  if (LVL > 0) begin : g_clear_chk
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
      start_acc |=> (result == '0)); // R8
  end

endmodule

// File: tb/bsdot_engine_tb.sv
module bsdot_engine_tb;

  localparam int TAPS = 5;
  localparam int CW   = 6;
  localparam int DW   = 7;
  localparam int LVL  = 3;
  localparam int AW   = CW + DW + LVL;

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 start;
  logic [TAPS*CW-1:0]   coef_bus;
  logic [TAPS-1:0]      data_bits;
  logic [AW-1:0]        result;
  logic                 result_valid;

  always #4 clk = ~clk;

  bsdot_engine #(.TAPS(TAPS), .CW(CW), .DW(DW)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .coef_bus     (coef_bus),
    .data_bits    (data_bits),
    .result       (result),
    .result_valid (result_valid)
  );

  int    checks = 0;
  int    fails  = 0;
  string scen   = "reset";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, exp);
    end
  endtask

  function automatic longint cval(input int t);
    longint v = longint'(coef_bus[t*CW +: CW]);
    if (v >= (longint'(1) << (CW - 1))) v -= (longint'(1) << CW);
    return v;
  endfunction

  function automatic longint contrib(input int k);
    longint s = 0;
    longint w;
    for (int t = 0; t < TAPS; t++) if (data_bits[t]) s += cval(t);
    w = longint'(1) << k;
    if (k == DW - 1) w = -w;
    return s * w;
  endfunction

  function automatic longint sres();
    longint r = longint'(result);
    if (result[AW-1]) r -= (longint'(1) << AW);
    return r;
  endfunction

  // Behavioural reference, updated on every rising edge
  bit     m_busy, m_ob, m_vld, m_known, m_zero_ck;
  int     m_rem, m_k;
  longint m_acc, m_res;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_vld = 0; m_known = 1; m_res = 0; m_k = 0; m_zero_ck = 0;
    end else begin
      m_ob  = m_busy;
      m_vld = 0;
      if (m_zero_ck) begin m_known = 0; m_zero_ck = 0; end
      if (m_ob) begin
        m_rem--;
        if (m_rem == 0) begin m_vld = 1; m_busy = 0; m_res = m_acc; m_known = 1; end
      end
      if (!m_ob && start) begin
        m_busy = 1; m_rem = DW - 1 + LVL; m_acc = contrib(0); m_k = 1;
        m_res = 0; m_known = 1; m_zero_ck = 1;
      end else if (m_ob && m_k < DW) begin
        m_acc += contrib(m_k);
        m_k++;
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(result_valid == m_vld, m_vld ? "R4" : "R5", longint'(result_valid), longint'(m_vld));
      if (m_known) chk(sres() == m_res, m_zero_ck ? "R8" : "R2", sres(), m_res);
    end
  end

  logic [DW-1:0] dat [TAPS];

  task automatic run(input bit poke, input int gap);
    int guard = 0;
    start = 1'b1;
    for (int t = 0; t < TAPS; t++) data_bits[t] = dat[t][0];
    for (int k = 1; k < DW; k++) begin
      @(negedge clk);
      start = poke && (k == 2);                 // R6: restart during feed
      for (int t = 0; t < TAPS; t++) data_bits[t] = dat[t][k];
    end
    @(negedge clk);
    while (!result_valid && guard < 50) begin
      start = poke && (guard == 0);             // R6: restart during drain
      data_bits = TAPS'($urandom);              // R3: bits outside the run
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    for (int g = 0; g < gap; g++) begin
      data_bits = TAPS'($urandom);
      @(negedge clk);
    end
  endtask

  function automatic logic [TAPS*CW-1:0] rand_coefs();
    logic [TAPS*CW-1:0] c;
    for (int t = 0; t < TAPS; t++) c[t*CW +: CW] = CW'($urandom);
    return c;
  endfunction

  initial begin
    rst = 1'b1; start = 1'b0; coef_bus = '0; data_bits = '0;
    repeat (3) @(negedge clk);
    chk(result == '0, "R10", longint'(result), 0);
    chk(result_valid == 1'b0, "R10", longint'(result_valid), 0);
    rst = 1'b0;

    scen = "R10 start right after reset, zero data";
    coef_bus = rand_coefs();
    for (int t = 0; t < TAPS; t++) dat[t] = '0;
    run(0, 2);

    scen = "R1 single tap enabled";
    coef_bus = rand_coefs();
    for (int t = 0; t < TAPS; t++) dat[t] = (t == 2) ? DW'(1) : '0;
    run(0, 1);

    scen = "R3 bit weight ordering";
    coef_bus = '0; coef_bus[0 +: CW] = CW'(1);
    for (int t = 0; t < TAPS; t++) dat[t] = (t == 0) ? DW'(8) : '0;
    run(0, 1);

    scen = "R7 most negative both";
    for (int t = 0; t < TAPS; t++) begin
      coef_bus[t*CW +: CW] = {1'b1, {(CW-1){1'b0}}};
      dat[t] = {1'b1, {(DW-1){1'b0}}};
    end
    run(0, 1);

    scen = "R7 most negative coef, max data";
    for (int t = 0; t < TAPS; t++) dat[t] = {1'b0, {(DW-1){1'b1}}};
    run(0, 0);

    scen = "R6 restarts while busy";
    coef_bus = rand_coefs();
    for (int t = 0; t < TAPS; t++) dat[t] = DW'($urandom);
    run(1, 2);

    scen = "R9 back-to-back chain";
    for (int r = 0; r < 6; r++) begin
      coef_bus = rand_coefs();
      for (int t = 0; t < TAPS; t++) dat[t] = DW'($urandom);
      run(r[0], 0);
    end

    scen = "R2 random runs";
    for (int r = 0; r < 40; r++) begin
      coef_bus = rand_coefs();
      for (int t = 0; t < TAPS; t++) dat[t] = DW'($urandom);
      run(($urandom % 3) == 0, $urandom % 4);
    end

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog [%s] actual=%0d expected=%0d", scen, 100000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule